// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a freshly powered SDRAM device into service for a single-channel memory controller. It waits idle after reset until it sees a one-cycle start pulse. It then waits a power-stabilisation interval and issues a fixed series of commands: a no-operation, a precharge of all banks, a burst of auto-refresh commands and a mode-register load. Each command is followed by its own wait. The series ends with a switch to normal operation, and only after that does the block tell the refresh engine that periodic refresh may run.

Each command appears as a 3-bit mode code together with a one-cycle strobe. The command path of the controller turns these into device pin activity. For the mode-register load, the block also presents the address word that the device latches. All waits are counted in clock cycles. The power-up interval is derived from the clock frequency in MHz, given as a parameter.

The CAS latency bit and the row-precharge bit are sampled once, when the start pulse is accepted. Changes to them after that have no effect on the running sequence.

Top module: `sdram_init_seq`

## Requirements
- R1: `cmd_mode` uses the codes 000 normal, 001 NOP, 010 precharge all, 011 mode register set, 100 auto-refresh. The codes 101, 110 and 111 never appear.
- R2: After reset, `cmd_mode`=000, `cmd_stb`=0, `mrs_addr`=0, `done`=0 and `refresh_en`=0. No strobe is issued until a start pulse is seen.
- R3: The NOP strobe follows the clock edge that samples `start` by exactly CLK_MHZ*PWR_US cycles.
- R4: The precharge-all strobe comes NOP_WAIT cycles after the NOP strobe.
- R5: The first refresh strobe comes 2 cycles after the precharge strobe when `cfg_rp2`=1, and 3 cycles after it when `cfg_rp2`=0.
- R6: Exactly REF_COUNT refresh strobes are issued, each T_RC cycles after the previous one. The mode-register strobe comes T_RC cycles after the last refresh strobe.
- R7: From the mode-register strobe onward, `mrs_addr` holds the burst length code 010 (four beats) in bits [2:0], 0 (sequential burst) in bit 3, and the CAS latency in bits [6:4]: 010 when `cfg_cas2`=1, 011 when it is 0. All higher bits are zero.
- R8: The normal-operation strobe, with code 000, comes MRS_WAIT cycles after the mode-register strobe.
- R9: `done` and `refresh_en` both go high one cycle after the normal strobe, and neither is high before that. They stay high until reset, and no further strobe is issued.
- R10: A start pulse while the sequence runs, or after `done`, has no effect. The configuration bits are sampled only when start is accepted.
- R11: `cmd_stb` lasts one cycle per command. `cmd_mode` keeps its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that launches the sequence |
| cfg_cas2 | input | 1 | 1 selects CAS latency 2, 0 selects 3 |
| cfg_rp2 | input | 1 | 1 selects a 2-cycle row precharge, 0 selects 3 |
| cmd_mode | output | 3 | Current command mode code |
| cmd_stb | output | 1 | One-cycle pulse when a command is issued |
| mrs_addr | output | ADDR_W | Address word for the mode-register load |
| done | output | 1 | Sequence complete, device in normal mode |
| refresh_en | output | 1 | Periodic refresh may run |

## Verification
Nearly any corruption of the phase register or of the wait counter moves a strobe in time. Every gap between two strobes has a known length, so a fault shows at the ports no later than the next strobe. A refresh counter that is off by one gives one refresh too many or too few, and the mode-register strobe then lands T_RC cycles early or late. A wrong sampled configuration bit shows either in the precharge-to-refresh gap or in bits [6:4] of the mode-register address. The bench varies both bits between runs and changes them in the middle of a run.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int CLK_MHZ   = 100,
  parameter int PWR_US    = 200,
  parameter int NOP_WAIT  = 200,
  parameter int REF_COUNT = 8,
  parameter int T_RC      = 8,
  parameter int MRS_WAIT  = 2,
  parameter int ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_cas2,
  input  logic              cfg_rp2,
  output logic [2:0]        cmd_mode,
  output logic              cmd_stb,
  output logic [ADDR_W-1:0] mrs_addr,
  output logic              done,
  output logic              refresh_en
);

  localparam int PWR_CYC = CLK_MHZ * PWR_US;
  localparam int MAXW1 = (PWR_CYC > NOP_WAIT) ? PWR_CYC : NOP_WAIT;
  localparam int MAXW2 = (T_RC > MRS_WAIT) ? T_RC : MRS_WAIT;
  localparam int MAXW  = ((MAXW1 > MAXW2) ? MAXW1 : MAXW2) + 3;
  localparam int CW    = $clog2(MAXW + 1);
  localparam int RW    = $clog2(REF_COUNT + 1);

  localparam logic [2:0] M_NORM = 3'b000;
  localparam logic [2:0] M_NOP  = 3'b001;
  localparam logic [2:0] M_PRE  = 3'b010;
  localparam logic [2:0] M_MRS  = 3'b011;
  localparam logic [2:0] M_REF  = 3'b100;

  typedef enum logic [2:0] {
    S_IDLE, S_PWR, S_NOP, S_PRE, S_REF, S_MRS, S_NORM, S_DONE
  } phase_t;

  phase_t          phase;
  logic [CW-1:0]   cnt;
  logic [RW-1:0]   ref_n;
  logic            cas_q, rp_q;
  logic            zero;
  logic [ADDR_W-1:0] mrs_val;

  assign zero    = (cnt == '0);
  assign mrs_val = ADDR_W'({cas_q ? 3'b010 : 3'b011, 1'b0, 3'b010});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= S_IDLE;
      cnt        <= '0;
      ref_n      <= '0;
      cas_q      <= 1'b0;
      rp_q       <= 1'b0;
      cmd_mode   <= M_NORM;
      cmd_stb    <= 1'b0;
      mrs_addr   <= '0;
      done       <= 1'b0;
      refresh_en <= 1'b0;
    end else begin
      cmd_stb <= 1'b0;
      if (phase != S_IDLE && phase != S_DONE && !zero) begin
        cnt <= cnt - 1'b1;
      end else begin
        case (phase)
          S_IDLE: if (start) begin
            cas_q <= cfg_cas2;
            rp_q  <= cfg_rp2;
            cnt   <= CW'(PWR_CYC - 1);
            phase <= S_PWR;
          end
          S_PWR: begin
            cmd_mode <= M_NOP;
            cmd_stb  <= 1'b1;
            cnt      <= CW'(NOP_WAIT - 1);
            phase    <= S_NOP;
          end
          S_NOP: begin
            cmd_mode <= M_PRE;
            cmd_stb  <= 1'b1;
            cnt      <= rp_q ? CW'(1) : CW'(2);
            phase    <= S_PRE;
          end
          S_PRE: begin
            cmd_mode <= M_REF;
            cmd_stb  <= 1'b1;
            cnt      <= CW'(T_RC - 1);
            ref_n    <= RW'(1);
            phase    <= S_REF;
          end
          S_REF: begin
            cmd_stb <= 1'b1;
            if (ref_n == RW'(REF_COUNT)) begin
              cmd_mode <= M_MRS;
              mrs_addr <= mrs_val;
              cnt      <= CW'(MRS_WAIT - 1);
              phase    <= S_MRS;
            end else begin
              cmd_mode <= M_REF;
              ref_n    <= ref_n + 1'b1;
              cnt      <= CW'(T_RC - 1);
            end
          end
          S_MRS: begin
            cmd_mode <= M_NORM;
            cmd_stb  <= 1'b1;
            phase    <= S_NORM;
          end
          S_NORM: begin
            done       <= 1'b1;
            refresh_en <= 1'b1;
            phase      <= S_DONE;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cmd_mode,
  input logic              cmd_stb,
  input logic [ADDR_W-1:0] mrs_addr,
  input logic              done,
  input logic              refresh_en
);

  assert_legal_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_mode <= 3'b100);

  assert_stb_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);

  assert_mode_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_stb |-> $stable(cmd_mode));

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && refresh_en);

  assert_refresh_after_normal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refresh_en) |-> done && $past(cmd_stb) && $past(cmd_mode) == 3'b000);

  assert_quiet_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_stb);

  assert_addr_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(mrs_addr));

endmodule

bind sdram_init_seq sdram_init_seq_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_mode(cmd_mode), .cmd_stb(cmd_stb),
  .mrs_addr(mrs_addr), .done(done), .refresh_en(refresh_en)
);

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;
  localparam int CLK_MHZ = 2, PWR_US = 200, NOP_WAIT = 200;
  localparam int REF_COUNT = 8, T_RC = 6, MRS_WAIT = 2, ADDR_W = 12;
  localparam int PWR_CYC = CLK_MHZ * PWR_US;

  logic clk = 0, rst_n = 0, start = 0, cfg_cas2 = 0, cfg_rp2 = 0;
  logic [2:0] cmd_mode;
  logic cmd_stb, done, refresh_en;
  logic [ADDR_W-1:0] mrs_addr;
  int errors = 0, checks = 0, cycles = 0;

  always #2.5 clk = ~clk;

  sdram_init_seq #(.CLK_MHZ(CLK_MHZ), .PWR_US(PWR_US), .NOP_WAIT(NOP_WAIT),
    .REF_COUNT(REF_COUNT), .T_RC(T_RC), .MRS_WAIT(MRS_WAIT), .ADDR_W(ADDR_W))
  i_sdram_init_seq (.clk(clk), .rst_n(rst_n), .start(start), .cfg_cas2(cfg_cas2),
    .cfg_rp2(cfg_rp2), .cmd_mode(cmd_mode), .cmd_stb(cmd_stb), .mrs_addr(mrs_addr),
    .done(done), .refresh_en(refresh_en));

  function automatic int exp_trp(logic rp);
    return rp ? 2 : 3;
  endfunction

  function automatic logic [ADDR_W-1:0] exp_mrs(logic cas);
    return ADDR_W'({cas ? 3'b010 : 3'b011, 1'b0, 3'b010});
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic expect_cmd(logic [2:0] mode, int gap, string tag, bit poke);
    int n = 0;
    int drift = 0;
    logic [2:0] held = cmd_mode;
    do begin
      @(negedge clk);
      n++;
      if (poke && n == 5) start = 1;
      if (poke && n == 6) start = 0;
      if (!cmd_stb && cmd_mode != held) drift++;
    end while (!cmd_stb && n < 5000);
    check(n == gap, {tag, " gap"}, n, gap);
    check(cmd_mode == mode, "R1 mode code", cmd_mode, mode);
    check(drift == 0, "R11 mode held", drift, 0);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check(cmd_mode == 0 && !cmd_stb && mrs_addr == 0 && !done && !refresh_en,
          "R2 reset state", {cmd_mode, cmd_stb, done, refresh_en}, 0);
    begin
      int s = 0;
      repeat (20) begin @(negedge clk); if (cmd_stb) s++; end
      check(s == 0, "R2 idle without start", s, 0);
    end
  endtask

  task automatic run_seq(logic cas, logic rp, bit disturb);
    cfg_cas2 = cas; cfg_rp2 = rp;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    if (disturb) begin cfg_cas2 = ~cas; cfg_rp2 = ~rp; end
    expect_cmd(3'b001, PWR_CYC, "R3 power wait", 1'b0);
    expect_cmd(3'b010, NOP_WAIT, disturb ? "R10 start ignored R4" : "R4 nop wait", disturb);
    expect_cmd(3'b100, exp_trp(rp), disturb ? "R10 latched R5" : "R5 precharge wait", 1'b0);
    for (int i = 1; i < REF_COUNT; i++)
      expect_cmd(3'b100, T_RC, "R6 refresh spacing", 1'b0);
    expect_cmd(3'b011, T_RC, "R6 refresh count", 1'b0);
    check(mrs_addr == exp_mrs(cas), "R7 mode address", mrs_addr, exp_mrs(cas));
    check(!done && !refresh_en, "R9 not early", {done, refresh_en}, 0);
    expect_cmd(3'b000, MRS_WAIT, "R8 normal", 1'b0);
    check(!done && !refresh_en, "R9 not at normal", {done, refresh_en}, 0);
    @(negedge clk);
    check(done && refresh_en, "R9 done", {done, refresh_en}, 3);
    begin
      int s = 0, lost = 0;
      for (int k = 0; k < 40; k++) begin
        start = (k == 10);
        @(negedge clk);
        if (cmd_stb) s++;
        if (!done || !refresh_en) lost++;
      end
      start = 0;
      check(s == 0, "R10 start after done", s, 0);
      check(lost == 0, "R9 sticky", lost, 0);
      check(mrs_addr == exp_mrs(cas), "R7 address kept", mrs_addr, exp_mrs(cas));
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    run_seq(1'b1, 1'b1, 1'b0);
    do_reset();
    run_seq(1'b0, 1'b0, 1'b0);
    do_reset();
    run_seq(1'b1, 1'b0, 1'b1);
    do_reset();
    run_seq(1'b0, 1'b1, 1'b1);
    for (int r = 0; r < 4; r++) begin
      logic c = $urandom % 2;
      logic p = $urandom % 2;
      bit d = $urandom % 2;
      do_reset();
      run_seq(c, p, d);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule